// File: doc/BRIEF.md
# Transport Stream Packet Aligner and Descrambler

This block sits after forward error correction in a satellite receive chain. It takes one byte per handshake from a stream of 204-byte packets: a sync byte, 187 payload bytes and 16 parity bytes. It finds the packet boundaries by looking for the sync value 0x47 or its bit inverse 0xB8 at a fixed 204-byte spacing. Lock is declared and released with hysteresis. Once the packets are aligned, the block removes the energy-dispersal scrambling from the payload bytes. The scrambler is a 15-bit pseudo-random generator that restarts at every inverted sync byte. The inverted sync byte is expected once in every group of eight packets.

Each input byte gives one output byte, together with a packet-window flag. The flag is high for the sync byte and the payload bytes, and low for the parity bytes. Two status pins are plain levels: one for packet lock and one for the eight-packet descrambler check. Both stream ports use valid/ready. An input byte is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the single output register is empty or is being emptied in the same cycle. The output holds its byte and flag stable while `out_valid` is high and `out_ready` is low.

Top module: `tsd_top`

## Requirements
- R1: After reset, `out_valid`, `pkt_lock` and `scr_sync` are low and `in_ready` is high.
- R2: `in_ready` equals (not `out_valid`) or `out_ready`. Each accepted byte appears exactly once at the output, in order. While `out_valid` is high and `out_ready` is low, `out_data` and `out_pktclk` hold.
- R3: While the block is hunting, a byte equal to 0x47 or 0xB8 starts a packet window at position 0 and is output with `out_pktclk` high. Any other byte passes through unchanged with `out_pktclk` low.
- R4: `pkt_lock` rises after three consecutive sync bytes (0x47 or 0xB8), each 204 accepted bytes after the previous one. Before lock, a missing sync byte at the expected position sends the block back to hunting, and that position byte is output with `out_pktclk` high.
- R5: Once locked, one or two consecutive missing sync bytes leave `pkt_lock` high. The third consecutive miss clears it and returns the block to hunting from the next byte.
- R6: While aligned, `out_pktclk` is high for positions 0 to 187 of the packet and low for positions 188 to 203.
- R7: The descrambling mask comes from the generator x^15+x^14+1. The register holds stages 1..15, and stages 1..15 reset to 100101010000000. Each step produces the bit (stage 14 XOR stage 15) and shifts that bit into stage 1. Eight steps make one mask byte, with the first bit as bit 7. The mask is XORed into payload positions 1 to 187. Sync positions and parity bytes pass through unchanged. A sync position that is not reseeded still advances the generator by 8 bits. Parity bytes hold it.
- R8: Every 0xB8 accepted at a sync position reloads the seed. The next payload byte uses the first mask byte of the sequence.
- R9: `scr_sync` rises when 0xB8 arrives at a sync position exactly eight packets after the previous reseed. It falls when the sync byte at that expected eighth-packet position is not 0xB8.
- R10: When the expected 0xB8 is missing, the seed is still reloaded at that position, so descrambling keeps the established eight-packet phase.
- R11: When packet lock is lost, `scr_sync` clears and descrambling stops until a 0xB8 is accepted again in an aligned window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Decoded byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink takes the output byte this cycle |
| out_data | output | 8 | Descrambled or passed-through byte |
| out_pktclk | output | 1 | High for sync and payload positions, low for parity and unaligned bytes |
| pkt_lock | output | 1 | Packet alignment locked |
| scr_sync | output | 1 | Eight-packet inverted-sync check passing |

## Verification
The bench sends one continuous stream under irregular back-pressure, and every output byte is compared against a mask table derived from the polynomial.

The stream includes a false sync byte while hunting; a design that locked on spacing alone would raise `pkt_lock` there. A single corrupted sync byte follows later, then a run of three; a design without hysteresis would drop lock at the first, and one with a wrong miss count would drop at the wrong packet. A 0x47 placed where 0xB8 belongs tests reseeding: a design that reseeded only on 0xB8 would descramble the next eight packets with a drifted mask. After lock is lost, re-locking on 0x47 tests that payload stays unscrambled until the next 0xB8; a design that kept its old phase would corrupt those packets.

// File: rtl/tsd_pkg.sv
package tsd_pkg;
  localparam logic [7:0]  SYNC_BYTE = 8'h47;
  localparam logic [7:0]  SYNC_INV  = 8'hB8;
  // stages 1..15 held in bits 0..14, stage 1 = bit 0
  localparam logic [14:0] PRBS_SEED = 15'h00A9;

  typedef enum logic [1:0] {ST_HUNT, ST_CHECK, ST_LOCK} align_e;

  typedef struct packed {
    logic [14:0] st;
    logic [7:0]  mask;
  } prbs_out_t;

  function automatic prbs_out_t prbs_step8(input logic [14:0] s);
    prbs_out_t r;
    logic fb;
    r.st   = s;
    r.mask = '0;
    for (int b = 7; b >= 0; b--) begin
      fb        = r.st[13] ^ r.st[14];
      r.st      = {r.st[13:0], fb};
      r.mask[b] = fb;
    end
    return r;
  endfunction
endpackage

// File: rtl/tsd_align.sv
module tsd_align
  import tsd_pkg::*;
#(
  parameter int PKT_LEN = 204,
  parameter int PAY_LEN = 188,
  parameter int LOCK_N  = 3,
  parameter int LOSS_N  = 3,
  localparam int POS_W  = $clog2(PKT_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [7:0]       data,
  output logic             slot_sync,
  output logic             slot_pay,
  output logic             slot_par,
  output logic             drop,
  output logic             aligned,
  output logic             lock,
  output logic [POS_W-1:0] pos
);
  localparam int CNT_MAX = (LOCK_N > LOSS_N) ? LOCK_N : LOSS_N;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(PKT_LEN - 1);
  localparam logic [POS_W-1:0] POS_PAY  = POS_W'(PAY_LEN);
  localparam logic [CNT_W-1:0] LOCK_TOP = CNT_W'(LOCK_N - 1);
  localparam logic [CNT_W-1:0] LOSS_TOP = CNT_W'(LOSS_N - 1);

  align_e           st;
  logic [CNT_W-1:0] hits, miss;
  logic             is_sync, at_zero;
  logic [POS_W-1:0] pos_nx;

  always_comb begin
    is_sync   = (data == SYNC_BYTE) || (data == SYNC_INV);
    aligned   = (st != ST_HUNT);
    lock      = (st == ST_LOCK);
    at_zero   = (pos == '0);
    slot_sync = aligned ? at_zero : is_sync;
    slot_pay  = aligned && !at_zero && (pos < POS_PAY);
    slot_par  = aligned && (pos >= POS_PAY);
    drop      = aligned && at_zero && !is_sync &&
                ((st == ST_CHECK) || (miss == LOSS_TOP));
    pos_nx    = (pos == POS_LAST) ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_HUNT;
      hits <= '0;
      miss <= '0;
      pos  <= '0;
    end else if (acc) begin
      unique case (st)
        ST_HUNT: if (is_sync) begin
          st   <= ST_CHECK;
          hits <= CNT_W'(1);
          pos  <= POS_W'(1);
        end
        ST_CHECK: begin
          pos <= pos_nx;
          if (at_zero) begin
            if (!is_sync) st <= ST_HUNT;
            else if (hits == LOCK_TOP) begin
              st   <= ST_LOCK;
              miss <= '0;
            end else hits <= hits + 1'b1;
          end
        end
        default: begin
          pos <= pos_nx;
          if (at_zero) begin
            if (is_sync) miss <= '0;
            else if (miss == LOSS_TOP) st <= ST_HUNT;
            else miss <= miss + 1'b1;
          end
        end
      endcase
    end
  end

  a_r4_lock_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> ($past(st) == ST_CHECK) && ($past(hits) == LOCK_TOP));
  a_r5_lock_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock) |-> ($past(miss) == LOSS_TOP) && $past(acc));
endmodule

// File: rtl/tsd_phase.sv
module tsd_phase
  import tsd_pkg::*;
#(
  parameter int GRP_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic slot_sync,
  input  logic drop,
  input  logic is_inv,
  output logic reseed,
  output logic adv_sync,
  output logic have_phase,
  output logic rsync
);
  localparam int IDX_W = (GRP_N > 1) ? $clog2(GRP_N) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(GRP_N - 1);

  logic [IDX_W-1:0] pidx;
  logic             due, take;

  always_comb begin
    due      = have_phase && (pidx == IDX_LAST);
    take     = acc && slot_sync && !drop;
    reseed   = take && (is_inv || due);
    adv_sync = take && have_phase && !reseed;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pidx       <= '0;
      have_phase <= 1'b0;
      rsync      <= 1'b0;
    end else if (acc && drop) begin
      pidx       <= '0;
      have_phase <= 1'b0;
      rsync      <= 1'b0;
    end else if (reseed) begin
      pidx       <= '0;
      have_phase <= 1'b1;
      rsync      <= is_inv && due;
    end else if (adv_sync) begin
      pidx <= pidx + 1'b1;
    end
  end

  a_r9_rsync_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsync) |-> $past(acc) && $past(is_inv));
  a_r11_rsync_needs_phase: assert property (@(posedge clk) disable iff (!rst_n)
    rsync |-> have_phase);
endmodule

// File: rtl/tsd_prbs.sv
module tsd_prbs
  import tsd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        adv,
  output logic [7:0]  mask,
  output logic [14:0] state
);
  prbs_out_t nx;

  always_comb begin
    nx   = prbs_step8(state);
    mask = nx.mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= PRBS_SEED;
    else if (load) state <= PRBS_SEED;
    else if (adv)  state <= nx.st;
  end
endmodule

// File: rtl/tsd_top.sv
module tsd_top
  import tsd_pkg::*;
#(
  parameter int PKT_LEN = 204,
  parameter int PAY_LEN = 188,
  parameter int LOCK_N  = 3,
  parameter int LOSS_N  = 3,
  parameter int GRP_N   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_pktclk,
  output logic       pkt_lock,
  output logic       scr_sync
);
  localparam int POS_W = $clog2(PKT_LEN);

  logic             acc, slot_sync, slot_pay, slot_par, drop, aligned, lock;
  logic [POS_W-1:0] pos;
  logic             reseed, adv_sync, have_phase, rsync, is_inv, scr_en;
  logic [7:0]       mask;
  logic [14:0]      prbs_st;

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;
  assign is_inv   = (in_data == SYNC_INV);
  assign scr_en   = slot_pay && have_phase;
  assign pkt_lock = lock;
  assign scr_sync = rsync;

  tsd_align #(.PKT_LEN(PKT_LEN), .PAY_LEN(PAY_LEN), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N))
  u_align (
    .clk(clk), .rst_n(rst_n), .acc(acc), .data(in_data),
    .slot_sync(slot_sync), .slot_pay(slot_pay), .slot_par(slot_par),
    .drop(drop), .aligned(aligned), .lock(lock), .pos(pos)
  );

  tsd_phase #(.GRP_N(GRP_N)) u_phase (
    .clk(clk), .rst_n(rst_n), .acc(acc), .slot_sync(slot_sync), .drop(drop),
    .is_inv(is_inv), .reseed(reseed), .adv_sync(adv_sync),
    .have_phase(have_phase), .rsync(rsync)
  );

  tsd_prbs u_prbs (
    .clk(clk), .rst_n(rst_n), .load(reseed),
    .adv((acc && scr_en) || adv_sync), .mask(mask), .state(prbs_st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_pktclk <= 1'b0;
    end else if (acc) begin
      out_valid  <= 1'b1;
      out_data   <= in_data ^ (scr_en ? mask : 8'h00);
      out_pktclk <= slot_sync || slot_pay;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_pktclk));
  a_r8_reseed_loads: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> prbs_st == PRBS_SEED);
  a_r7_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc && slot_par |=> $stable(prbs_st));
  a_r11_rsync_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rsync |-> aligned);
endmodule

// File: tb/sim_tsd_top.sv
module sim_tsd_top;
  localparam int NMAX = 16384;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_pktclk, pkt_lock, scr_sync;
  logic [7:0] out_data;

  always #4 clk = ~clk;

  tsd_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_pktclk(out_pktclk), .pkt_lock(pkt_lock),
    .scr_sync(scr_sync)
  );

  int checks = 0, failures = 0;
  logic [7:0] tbl [1504];
  logic [7:0] s_in [NMAX];
  logic [7:0] e_d  [NMAX];
  logic       e_pk [NMAX];
  logic       has_st [NMAX];
  logic       e_lk [NMAX];
  logic       e_rs [NMAX];
  string      tag  [NMAX];
  string      stag [NMAX];
  int n_in = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_byte(input logic [7:0] d, input logic [7:0] ed,
                          input logic ep, input string t);
    s_in[n_in] = d; e_d[n_in] = ed; e_pk[n_in] = ep; tag[n_in] = t;
    has_st[n_in] = 1'b0; n_in++;
  endtask

  // mode 0: aligned and descrambled, 1: aligned plain, 2: sync slot then hunting
  task automatic add_pkt(input int k, input logic [7:0] sb, input int mode,
                         input logic lk, input logic rs);
    int j;
    logic [7:0] v;
    string t;
    j = k % 8;
    t = (k >= 24 && k < 32) ? "R10" : (k >= 37 && k < 41) ? "R11" :
        (j == 0) ? "R8" : "R7";
    add_byte(sb, sb, 1'b1, "R6");
    has_st[n_in-1] = 1'b1; e_lk[n_in-1] = lk; e_rs[n_in-1] = rs;
    stag[n_in-1] = (k >= 33 && k <= 37) ? "R5" :
                   (k == 24) ? "R10" : (k == 37) ? "R11" : "R4/R9";
    for (int p = 1; p < 204; p++) begin
      v = 8'((k * 7 + p * 3) & 63);
      if (mode == 2)       add_byte(v, v, 1'b0, "R11");
      else if (p >= 188)   add_byte(v, v, 1'b0, "R6");
      else if (mode == 1)  add_byte(v, v, 1'b1, "R11");
      else                 add_byte(v, v ^ tbl[j * 188 + p - 1], 1'b1, t);
    end
  endtask

  initial begin
    logic [14:0] s;
    logic fb;
    logic [7:0] sb, v, hold_d;
    logic hold_pk, hold_on;
    int mode, ip, op, cyc, pend_idx;
    logic lk, rs, pend;

    // mask table from x^15+x^14+1, stages 1..15 = 100101010000000
    s = 15'b000000010101001;
    for (int n = 0; n < 1504; n++) begin
      for (int b = 7; b >= 0; b--) begin
        fb = s[13] ^ s[14];
        s = {s[13:0], fb};
        tbl[n][b] = fb;
      end
    end

    // false sync while hunting, then a failed spacing check
    add_byte(8'h47, 8'h47, 1'b1, "R3");
    for (int i = 1; i < 204; i++) begin
      v = 8'((i * 5) & 63);
      add_byte(v, v, (i < 188), "R6");
    end
    add_byte(8'h11, 8'h11, 1'b1, "R4");
    has_st[n_in-1] = 1'b1; e_lk[n_in-1] = 1'b0; e_rs[n_in-1] = 1'b0; stag[n_in-1] = "R4";
    for (int i = 0; i < 30; i++) begin
      v = 8'((i * 3) & 63);
      add_byte(v, v, 1'b0, "R3");
    end
    // aligned packets with group, miss and loss events
    for (int k = 0; k <= 50; k++) begin
      sb = (k % 8 == 0) ? 8'hB8 : 8'h47;
      if (k == 24) sb = 8'h47;
      if (k == 33 || k == 35 || k == 36 || k == 37) sb = 8'h00;
      mode = (k == 37) ? 2 : (k == 38 || k == 39) ? 1 : 0;
      lk = !((k < 2) || (k >= 37 && k <= 39));
      rs = (k >= 8 && k <= 23) || (k >= 32 && k <= 36) || (k >= 48);
      add_pkt(k, sb, mode, lk, rs);
    end

    // reset
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
    chk(pkt_lock == 1'b0, "R1", "pkt_lock", pkt_lock, 0);
    chk(scr_sync == 1'b0, "R1", "scr_sync", scr_sync, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    rst_n = 1'b1;

    ip = 0; op = 0; cyc = 0; pend = 1'b0; pend_idx = 0; hold_on = 1'b0;
    hold_d = 8'h00; hold_pk = 1'b0;
    while (op < n_in && cyc < 150000) begin
      @(negedge clk);
      if (pend) begin
        chk(pkt_lock == e_lk[pend_idx], stag[pend_idx], $sformatf("pkt_lock byte %0d", pend_idx),
            pkt_lock, e_lk[pend_idx]);
        chk(scr_sync == e_rs[pend_idx], stag[pend_idx], $sformatf("scr_sync byte %0d", pend_idx),
            scr_sync, e_rs[pend_idx]);
        pend = 1'b0;
      end
      if (hold_on) begin
        chk(out_valid && out_data == hold_d && out_pktclk == hold_pk, "R2",
            "held output", out_data, hold_d);
        hold_on = 1'b0;
      end
      out_ready = (cyc % 5) != 3;
      in_valid  = (ip < n_in) && ((cyc % 7) != 2);
      in_data   = in_valid ? s_in[ip] : 8'h00;
      #1;
      if ((cyc % 97) == 0)
        chk(in_ready == (!out_valid || out_ready), "R2", "in_ready", in_ready,
            (!out_valid || out_ready));
      if (out_valid && out_ready) begin
        chk(out_data == e_d[op], tag[op], $sformatf("data byte %0d", op), out_data, e_d[op]);
        chk(out_pktclk == e_pk[op], tag[op], $sformatf("pktclk byte %0d", op),
            out_pktclk, e_pk[op]);
        op++;
      end else if (out_valid) begin
        hold_on = 1'b1; hold_d = out_data; hold_pk = out_pktclk;
      end
      if (in_valid && in_ready) begin
        if (has_st[ip]) begin pend = 1'b1; pend_idx = ip; end
        ip++;
      end
      cyc++;
    end
    if (op < n_in) begin
      checks++; failures++;
      $display("FAIL R2 watchdog outputs=%0d expected=%0d", op, n_in);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule